// File: doc/BRIEF.md
# POS HDLC Receive Deframer

This block sits behind a SONET payload extractor. It takes a stream of payload octets and recovers the packets carried in them as byte-synchronous HDLC frames. Each octet is first descrambled with a self-synchronous x^43+1 descrambler, which can be switched off. The block then hunts for the first flag and splits the stream at flag octets, where one flag may close one frame and open the next. It undoes control-escape stuffing, recognises aborts, checks the frame check sequence as CRC-16 or CRC-32 (or skips the check), optionally drops the FCS octets from the delivered data, and applies programmable minimum and maximum length limits.

Packets leave on an octet stream with valid, start, end and error markers. Each finished frame also gives a single-cycle verdict pulse that says whether it was good, failed its FCS, was aborted, was too short (runt) or was too long (giant). Configuration inputs are read at frame close and must be held stable while a frame is in flight.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset the block ignores every octet until it sees the first flag (0x7E). Octets seen before that flag produce no output data and no verdict pulse.
- R2: Consecutive flags with nothing between them produce no packet and no pulse. A single flag between two frames closes the first frame and opens the second.
- R3: Inside a frame the escape octet 0x7D is discarded, and the octet after it is delivered XORed with 0x20.
- R4: An escape octet followed at once by a flag (0x7D, 0x7E) ends the current frame with an abort pulse. That flag also opens the next frame.
- R5: With checking on and 16-bit mode selected, the CRC runs over the frame octets LSB first, using the reflected polynomial 0x8408 and a preset of 0xFFFF. The frame is good when the register holds 0xF0B8 after the last octet. The transmitted FCS is the complemented CRC, sent low octet first.
- R6: With checking on and 32-bit mode selected, the CRC runs over the frame octets LSB first, using the reflected polynomial 0xEDB88320 and a preset of 0xFFFFFFFF. The frame is good when the register holds 0xDEBB20E3. The FCS is sent as four octets, low octet first.
- R7: With checking off, no FCS is assumed. Every destuffed octet is delivered and no bad-FCS verdict is given.
- R8: With checking and stripping both on, the last 2 octets (16-bit mode) or 4 octets (32-bit mode) of a frame are withheld from the output. Without stripping, they are delivered.
- R9: A frame whose destuffed length L, counting FCS octets, is below the minimum, or with checking on is no longer than the FCS, gets a runt pulse. A 1-octet frame with checking off is good.
- R10: A frame with L above the maximum gets a giant pulse. L equal to the maximum or to the minimum is accepted.
- R11: Each closed frame raises exactly one pulse, chosen by priority: abort, then runt, then giant, then bad-FCS, then good. The end octet carries the error marker exactly when the verdict is not good.
- R12: With descrambling on, each received bit is XORed with the received bit 43 positions earlier, LSB of each octet first. The history is cleared by reset and advances on every accepted octet.
- R13: A packet of L octets delivers max(0, L - H + 1) octets, where H is 1 without stripping and FCS length + 1 with stripping. Start marks the first delivered octet and end marks the last. The end octet and the verdict pulse appear in the cycle after the closing flag is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An octet is present on inOctet |
| inOctet | input | 8 | Received payload octet, possibly scrambled |
| descrEn | input | 1 | Enable x^43+1 descrambling |
| crcEn | input | 1 | Enable FCS checking |
| crc32Sel | input | 1 | 1 selects CRC-32, 0 selects CRC-16 |
| stripFcs | input | 1 | Withhold FCS octets from output when checking |
| minLen | input | LEN_W | Minimum accepted frame length in octets |
| maxLen | input | LEN_W | Maximum accepted frame length in octets |
| outValid | output | 1 | A packet octet is on outData |
| outData | output | 8 | Delivered packet octet |
| outSop | output | 1 | First octet of a packet |
| outEop | output | 1 | Last octet of a packet |
| outErr | output | 1 | Packet ended with a non-good verdict (on end octet) |
| goodPulse | output | 1 | Frame closed good |
| badFcsPulse | output | 1 | Frame closed with FCS mismatch |
| abortPulse | output | 1 | Frame closed by abort |
| runtPulse | output | 1 | Frame closed too short |
| giantPulse | output | 1 | Frame closed too long |

## Verification
The properties assume that octets arrive only when inValid is high and that length limits and mode selects do not change while a frame is open. Under those assumptions, end and start markers pair up and every end octet coincides with exactly one verdict pulse. The stimulus changes configuration only on idle cycles after a closing flag has been taken. It also inserts idle cycles inside frames to show that gaps on inValid do not disturb destuffing, the CRC or descrambler history.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [7:0] FLAG_OCTET = 8'h7E;
  localparam logic [7:0] ESC_OCTET  = 8'h7D;
  localparam logic [7:0] ESC_MASK   = 8'h20;

  localparam logic [15:0] CRC16_POLY = 16'h8408;
  localparam logic [15:0] CRC16_INIT = 16'hFFFF;
  localparam logic [15:0] CRC16_GOOD = 16'hF0B8;
  localparam logic [31:0] CRC32_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC32_INIT = 32'hFFFFFFFF;
  localparam logic [31:0] CRC32_GOOD = 32'hDEBB20E3;

  localparam int FCS16_BYTES   = 2;
  localparam int FCS32_BYTES   = 4;
  localparam int MAX_FCS_BYTES = FCS32_BYTES;

  typedef enum logic {ST_HUNT, ST_FRAME} rxState_t;

  typedef enum logic [2:0] {
    END_GOOD, END_BADFCS, END_ABORT, END_RUNT, END_GIANT
  } endKind_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic open;      // a new frame begins after this octet
    logic push;      // deliver one destuffed octet into the frame
    logic unescape;  // the pushed octet follows an escape
    logic close;     // flag ends a non-empty frame
    logic abort;     // escape followed by flag ends the frame
  } ctrlStrobe_t;
endpackage

// File: rtl/hdlc_descrambler.sv
module hdlc_descrambler #(
  parameter int LAG = 43
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       octetValid,
  input  logic       enable,
  input  logic [7:0] rawOctet,
  output logic [7:0] plainOctet
);
  logic [LAG-1:0] hist;
  logic [LAG-1:0] histNext;
  logic [7:0]     descr;

  // LSB first, each bit XORed with the received bit LAG positions back
  always_comb begin
    histNext = hist;
    descr    = '0;
    for (int i = 0; i < 8; i++) begin
      descr[i] = rawOctet[i] ^ histNext[LAG-1];
      histNext = {histNext[LAG-2:0], rawOctet[i]};
    end
    plainOctet = enable ? descr : rawOctet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) hist <= '0;
    else if (octetValid) hist <= histNext;
  end
endmodule

// File: rtl/hdlc_crc_unit.sv
module hdlc_crc_unit #(
  parameter int               WIDTH = 16,
  parameter logic [WIDTH-1:0] POLY  = '0,
  parameter logic [WIDTH-1:0] INIT  = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             update,
  input  logic [7:0]       octet,
  output logic [WIDTH-1:0] crc
);
  logic [WIDTH-1:0] crcNext;

  always_comb begin
    crcNext = crc;
    for (int i = 0; i < 8; i++) begin
      if (crcNext[0] ^ octet[i]) crcNext = (crcNext >> 1) ^ POLY;
      else                       crcNext = crcNext >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) crc <= INIT;
    else if (update)    crc <= crcNext;
  end
endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        octetValid,
  input  logic [7:0]  octet,
  input  logic        emptyFrame,
  output ctrlStrobe_t stb
);
  rxState_t state;
  logic     escPend;
  logic     isFlag;
  logic     isEsc;

  assign isFlag = (octet == FLAG_OCTET);
  assign isEsc  = (octet == ESC_OCTET);

  always_comb begin
    stb = '0;
    if (octetValid) begin
      if (state == ST_HUNT) begin
        stb.open = isFlag;
      end else if (escPend) begin
        if (isFlag) begin
          stb.abort = 1'b1;
          stb.open  = 1'b1;
        end else begin
          stb.push     = 1'b1;
          stb.unescape = 1'b1;
        end
      end else if (isFlag) begin
        stb.close = !emptyFrame;
        stb.open  = 1'b1;
      end else if (!isEsc) begin
        stb.push = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      escPend <= 1'b0;
    end else if (octetValid) begin
      if (stb.open) state <= ST_FRAME;
      escPend <= (state == ST_FRAME) && !escPend && isEsc;
    end
  end
endmodule

// File: rtl/hdlc_rx_datapath.sv
module hdlc_rx_datapath
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  logic [7:0]       octet,
  input  logic             crcEn,
  input  logic             crc32Sel,
  input  logic             stripFcs,
  input  logic [LEN_W-1:0] minLen,
  input  logic [LEN_W-1:0] maxLen,
  output logic             emptyFrame,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outSop,
  output logic             outEop,
  output logic             outErr,
  output logic             goodPulse,
  output logic             badFcsPulse,
  output logic             abortPulse,
  output logic             runtPulse,
  output logic             giantPulse
);
  localparam int HOLD_MAX = MAX_FCS_BYTES + 1;
  localparam int CNT_W    = $clog2(HOLD_MAX + 1);
  localparam logic [LEN_W-1:0] LEN_SAT = '1;

  logic [7:0]       frameData;
  logic [LEN_W-1:0] frameLen;
  logic [15:0]      crc16Val;
  logic [31:0]      crc32Val;

  logic [HOLD_MAX-1:0][7:0] holdBuf;
  logic [HOLD_MAX-1:0][7:0] holdNext;
  logic [CNT_W-1:0]         holdCnt;
  logic [CNT_W-1:0]         fcsBytes;
  logic [CNT_W-1:0]         depth;
  logic [7:0]               oldest;
  logic                     sopPend;

  logic     endNow, emitNow, flushNow;
  logic     isRunt, isGiant, crcBad;
  endKind_t kind;

  assign frameData  = stb.unescape ? (octet ^ ESC_MASK) : octet;
  assign emptyFrame = (frameLen == '0);

  // both CRC widths run side by side; the mode picks one at close
  hdlc_crc_unit #(.WIDTH(16), .POLY(CRC16_POLY), .INIT(CRC16_INIT)) u_crc16 (
    .clk(clk), .rstN(rstN), .clear(stb.open), .update(stb.push),
    .octet(frameData), .crc(crc16Val));

  hdlc_crc_unit #(.WIDTH(32), .POLY(CRC32_POLY), .INIT(CRC32_INIT)) u_crc32 (
    .clk(clk), .rstN(rstN), .clear(stb.open), .update(stb.push),
    .octet(frameData), .crc(crc32Val));

  always_ff @(posedge clk) begin
    if (!rstN || stb.open)                frameLen <= '0;
    else if (stb.push && frameLen != LEN_SAT) frameLen <= frameLen + 1'b1;
  end

  // hold line: deep enough to hide the FCS and still tag the last octet
  assign fcsBytes = crc32Sel ? CNT_W'(FCS32_BYTES) : CNT_W'(FCS16_BYTES);
  assign depth    = (crcEn && stripFcs) ? fcsBytes + 1'b1 : CNT_W'(1);
  assign oldest   = holdBuf[depth - 1'b1];

  assign holdNext[0] = frameData;
  for (genvar k = 1; k < HOLD_MAX; k++) begin : g_hold
    assign holdNext[k] = holdBuf[k-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdBuf <= '0;
    else if (stb.push) holdBuf <= holdNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.open)                 holdCnt <= '0;
    else if (stb.push && holdCnt < depth)  holdCnt <= holdCnt + 1'b1;
  end

  assign endNow   = stb.close | stb.abort;
  assign emitNow  = stb.push && (holdCnt == depth);
  assign flushNow = endNow && (holdCnt == depth);

  // frame verdict with fixed priority
  assign isRunt  = (frameLen < minLen) ||
                   (crcEn && frameLen <= LEN_W'(fcsBytes));
  assign isGiant = (frameLen > maxLen);
  assign crcBad  = crcEn && (crc32Sel ? (crc32Val != CRC32_GOOD)
                                      : (crc16Val != CRC16_GOOD));

  always_comb begin
    if (stb.abort)   kind = END_ABORT;
    else if (isRunt) kind = END_RUNT;
    else if (isGiant) kind = END_GIANT;
    else if (crcBad) kind = END_BADFCS;
    else             kind = END_GOOD;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           sopPend <= 1'b1;
    else if (stb.open)   sopPend <= 1'b1;
    else if (emitNow)    sopPend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outData     <= '0;
      outSop      <= 1'b0;
      outEop      <= 1'b0;
      outErr      <= 1'b0;
      goodPulse   <= 1'b0;
      badFcsPulse <= 1'b0;
      abortPulse  <= 1'b0;
      runtPulse   <= 1'b0;
      giantPulse  <= 1'b0;
    end else begin
      outValid    <= emitNow | flushNow;
      outData     <= oldest;
      outSop      <= sopPend & (emitNow | flushNow);
      outEop      <= flushNow;
      outErr      <= flushNow && (kind != END_GOOD);
      goodPulse   <= endNow && (kind == END_GOOD);
      badFcsPulse <= endNow && (kind == END_BADFCS);
      abortPulse  <= endNow && (kind == END_ABORT);
      runtPulse   <= endNow && (kind == END_RUNT);
      giantPulse  <= endNow && (kind == END_GIANT);
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int SCRAMBLE_LAG = 43
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inOctet,
  input  logic             descrEn,
  input  logic             crcEn,
  input  logic             crc32Sel,
  input  logic             stripFcs,
  input  logic [LEN_W-1:0] minLen,
  input  logic [LEN_W-1:0] maxLen,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outSop,
  output logic             outEop,
  output logic             outErr,
  output logic             goodPulse,
  output logic             badFcsPulse,
  output logic             abortPulse,
  output logic             runtPulse,
  output logic             giantPulse
);
  logic [7:0]  plainOctet;
  logic        emptyFrame;
  ctrlStrobe_t stb;

  hdlc_descrambler #(.LAG(SCRAMBLE_LAG)) u_descr (
    .clk(clk), .rstN(rstN), .octetValid(inValid), .enable(descrEn),
    .rawOctet(inOctet), .plainOctet(plainOctet));

  hdlc_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .octetValid(inValid), .octet(plainOctet),
    .emptyFrame(emptyFrame), .stb(stb));

  hdlc_rx_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .octet(plainOctet),
    .crcEn(crcEn), .crc32Sel(crc32Sel), .stripFcs(stripFcs),
    .minLen(minLen), .maxLen(maxLen), .emptyFrame(emptyFrame),
    .outValid(outValid), .outData(outData), .outSop(outSop),
    .outEop(outEop), .outErr(outErr), .goodPulse(goodPulse),
    .badFcsPulse(badFcsPulse), .abortPulse(abortPulse),
    .runtPulse(runtPulse), .giantPulse(giantPulse));
endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker (
  input logic clk,
  input logic rstN,
  input logic outValid,
  input logic outSop,
  input logic outEop,
  input logic outErr,
  input logic goodPulse,
  input logic badFcsPulse,
  input logic abortPulse,
  input logic runtPulse,
  input logic giantPulse
);
  logic inPkt;

  always_ff @(posedge clk) begin
    if (!rstN) inPkt <= 1'b0;
    else if (outValid) inPkt <= !outEop;
  end

  // R11
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({goodPulse, badFcsPulse, abortPulse, runtPulse, giantPulse}));

  // R13
  eop_with_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEop |-> (goodPulse || badFcsPulse || abortPulse || runtPulse || giantPulse));

  // R11
  eop_err_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEop |-> (outErr == !goodPulse));

  // R13
  sop_pairing_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSop == !inPkt));

  // R13
  marker_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outSop || outEop || outErr) |-> outValid);
endmodule

bind hdlc_rx_deframer hdlc_rx_checker u_rxChk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outSop(outSop),
  .outEop(outEop), .outErr(outErr), .goodPulse(goodPulse),
  .badFcsPulse(badFcsPulse), .abortPulse(abortPulse),
  .runtPulse(runtPulse), .giantPulse(giantPulse));

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;
  localparam int LEN_W = 16;

  typedef struct packed {
    logic [7:0] len;     // payload octets before FCS
    logic [7:0] seed;
    logic       crc32;
    logic       crcOn;
    logic       strip;
    logic       corrupt;
    logic       abrt;
    logic [7:0] minL;
    logic [7:0] maxL;
    logic [2:0] kind;    // 0 good 1 badfcs 2 abort 3 runt 4 giant
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{8'd6,  8'h10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 8'd64, 3'd0, 4'd5},  // R5
    '{8'd6,  8'h71, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 8'd64, 3'd0, 4'd3},  // R3 R8 flag in data
    '{8'd8,  8'h70, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 8'd64, 3'd0, 4'd6},  // R6 R3 escape in data
    '{8'd5,  8'h22, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 8'd64, 3'd0, 4'd8},  // R8
    '{8'd7,  8'h33, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd1, 8'd64, 3'd1, 4'd5},  // R5 bad FCS
    '{8'd7,  8'h44, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd1, 8'd64, 3'd1, 4'd6},  // R6 bad FCS
    '{8'd1,  8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd64, 3'd0, 4'd9},  // R9 R7 one octet
    '{8'd9,  8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8'd64, 3'd0, 4'd7},  // R7
    '{8'd4,  8'h66, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 8'd64, 3'd2, 4'd4},  // R4
    '{8'd2,  8'h12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 8'd64, 3'd2, 4'd4},  // R4 nothing delivered
    '{8'd3,  8'h13, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8, 8'd64, 3'd3, 4'd9},  // R9 below minimum
    '{8'd20, 8'h14, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 8'd16, 3'd4, 4'd10}, // R10 above maximum
    '{8'd2,  8'h15, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd6, 8'd64, 3'd3, 4'd11}, // R11 runt beats bad FCS
    '{8'd16, 8'h16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 8'd18, 3'd0, 4'd10}, // R10 equal to maximum
    '{8'd6,  8'h17, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8, 8'd64, 3'd0, 4'd9},  // R9 equal to minimum
    '{8'd0,  8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 8'd64, 3'd3, 4'd9}   // R9 FCS only
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inOctet = '0;
  logic descrEn = 1'b0, crcEn = 1'b0, crc32Sel = 1'b0, stripFcs = 1'b0;
  logic [LEN_W-1:0] minLen = 16'd1, maxLen = 16'd64;
  logic outValid, outSop, outEop, outErr;
  logic [7:0] outData;
  logic goodPulse, badFcsPulse, abortPulse, runtPulse, giantPulse;

  int checks = 0;
  int fails = 0;
  int gapCnt = 0;
  logic [42:0] txHist = '0;

  logic [7:0] capD [64];
  logic       capS [64];
  logic       capE [64];
  logic       capR [64];
  int capN = 0;
  int pulseKind [8];
  int pulseN = 0;

  logic [7:0] frm [64];
  int frmLen;

  always #4 clk = ~clk;

  hdlc_rx_deframer #(.LEN_W(LEN_W)) i_hdlc_rx_deframer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOctet(inOctet),
    .descrEn(descrEn), .crcEn(crcEn), .crc32Sel(crc32Sel), .stripFcs(stripFcs),
    .minLen(minLen), .maxLen(maxLen), .outValid(outValid), .outData(outData),
    .outSop(outSop), .outEop(outEop), .outErr(outErr), .goodPulse(goodPulse),
    .badFcsPulse(badFcsPulse), .abortPulse(abortPulse), .runtPulse(runtPulse),
    .giantPulse(giantPulse));

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && capN < 64) begin
        capD[capN] = outData; capS[capN] = outSop;
        capE[capN] = outEop;  capR[capN] = outErr;
        capN++;
      end
      if ((goodPulse | badFcsPulse | abortPulse | runtPulse | giantPulse) && pulseN < 8) begin
        pulseKind[pulseN] = goodPulse ? 0 : badFcsPulse ? 1 : abortPulse ? 2 : runtPulse ? 3 : 4;
        pulseN++;
      end
    end
  end

  task automatic check(input logic ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // scrambles when descrEn is set (R12 model), inserts a gap every 5 octets
  task automatic putOctet(input logic [7:0] b);
    logic [7:0] s;
    logic sb;
    gapCnt++;
    if (gapCnt % 5 == 0) begin
      @(negedge clk); inValid = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      sb = descrEn ? (b[i] ^ txHist[42]) : b[i];
      s[i] = sb;
      txHist = {txHist[41:0], sb};
    end
    @(negedge clk);
    inValid = 1'b1;
    inOctet = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); inValid = 1'b0;
    end
  endtask

  task automatic sendData(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin
      putOctet(8'h7D); putOctet(b ^ 8'h20);
    end else putOctet(b);
  endtask

  function automatic logic [31:0] crcCalc(input int n, input logic wide);
    logic [31:0] c;
    c = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ frm[k][i]) c = (c >> 1) ^ (wide ? 32'hEDB88320 : 32'h00008408);
        else c = c >> 1;
      end
    return c;
  endfunction

  task automatic runVector(input vec_t v, input int idx);
    int fcsW, fcsN, L, depth, deliv;
    logic [31:0] fcs;
    logic ok;
    fcsW = v.crc32 ? 4 : 2;
    fcsN = v.crcOn ? fcsW : 0;
    for (int i = 0; i < v.len; i++) frm[i] = v.seed + 8'(i * 13);
    L = v.len;
    if (v.crcOn && !v.abrt) begin
      fcs = ~crcCalc(v.len, v.crc32);
      for (int i = 0; i < fcsN; i++) frm[v.len + i] = fcs[8*i +: 8];
      if (v.corrupt) frm[v.len] = frm[v.len] ^ 8'h01;
      L = v.len + fcsN;
    end
    depth = (v.strip && v.crcOn) ? fcsW + 1 : 1;
    deliv = (L >= depth) ? L - depth + 1 : 0;
    crcEn = v.crcOn; crc32Sel = v.crc32; stripFcs = v.strip;
    minLen = LEN_W'(v.minL); maxLen = LEN_W'(v.maxL);
    capN = 0; pulseN = 0;
    for (int i = 0; i < L; i++) sendData(frm[i]);
    if (v.abrt) putOctet(8'h7D);
    putOctet(8'h7E);
    idle(4);
    check(pulseN == 1 && pulseKind[0] == int'(v.kind),
          $sformatf("R%0d vec %0d verdict: pulses=%0d kind=%0d expected 1 pulse kind=%0d",
                    v.req, idx, pulseN, pulseN > 0 ? pulseKind[0] : -1, v.kind));
    ok = (capN == deliv);
    for (int i = 0; i < capN && ok; i++)
      ok = (capD[i] == frm[i]) && (capS[i] == (i == 0)) &&
           (capE[i] == (i == deliv - 1)) &&
           (capR[i] == ((i == deliv - 1) && v.kind != 3'd0));
    check(ok, $sformatf("R%0d vec %0d data: %0d octets out, expected %0d (first %h vs %h)",
                        v.req, idx, capN, deliv, capN > 0 ? capD[0] : 8'h00,
                        deliv > 0 ? frm[0] : 8'h00));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R1..R13 incomplete)");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && !outSop && !outEop && !outErr && !goodPulse && !badFcsPulse &&
          !abortPulse && !runtPulse && !giantPulse,
          $sformatf("R13 reset state: outValid=%b pulses=%b expected all 0", outValid,
                    {goodPulse, badFcsPulse, abortPulse, runtPulse, giantPulse}));
    rstN = 1'b1;
    idle(2);

    // R1: octets before the first flag are ignored
    crcEn = 1'b0;
    putOctet(8'h11); putOctet(8'h22); putOctet(8'h33);
    putOctet(8'h7E); putOctet(8'h7E);
    idle(4);
    check(capN == 0 && pulseN == 0,
          $sformatf("R1 hunt: %0d octets %0d pulses, expected 0 and 0", capN, pulseN));

    // R2: back-to-back flags are idle fill
    putOctet(8'h7E); putOctet(8'h7E); putOctet(8'h7E);
    idle(4);
    check(capN == 0 && pulseN == 0,
          $sformatf("R2 idle flags: %0d octets %0d pulses, expected 0 and 0", capN, pulseN));

    for (int n = 0; n < NVEC; n++) runVector(VECS[n], n);

    // R12: scrambled line, descrambled in the block
    descrEn = 1'b1;
    putOctet(8'h7E); putOctet(8'h7E); putOctet(8'h7E);
    idle(2);
    runVector('{8'd10, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 8'd64, 3'd0, 4'd12}, 100);
    descrEn = 1'b0;
    idle(2);

    // R13: end octet and verdict one cycle after the closing flag
    crcEn = 1'b0; stripFcs = 1'b0; minLen = 16'd1; maxLen = 16'd64;
    putOctet(8'hA5); putOctet(8'h5A); putOctet(8'h7E);
    @(negedge clk);
    check(goodPulse && outEop && outValid && !outErr && outData == 8'h5A,
          $sformatf("R13 latency: good=%b eop=%b data=%h expected 1 1 5a",
                    goodPulse, outEop, outData));
    inValid = 1'b0;
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule